// File: doc/BRIEF.md
# Fixed-Period Chopper Gate Controller

This block holds the digital side of a constant-current chopper that drives one motor winding pair. A counter divides the fast system clock into a slow step tick, and a second counter groups those ticks into one fixed chopping period. All phases that share the same parameters chop in step. At each period boundary the gate of the active side turns on. The gate then runs until an over-current flag from an external comparator ends it. It stays off until the next boundary.

For a short window after each boundary the comparator flag is masked, so the spike that follows switch turn-on cannot end the pulse early. A sequencer supplies the winding polarity and a current-ratio code. When the polarity flips, both complementary gates are held low for a timed dead interval before the new side may conduct. A ratio code of zero keeps the gate low for a whole period. A low enable forces both gates low at once.

The pulse controller has four states. `CH_IDLE` waits for a boundary. `CH_BLANK` drives the gate with the flag masked. `CH_ON` drives the gate and watches the flag. `CH_TRIP` holds the gate off. The transitions are as follows:
- `CH_IDLE`→`CH_BLANK` at a boundary when enabled with a nonzero ratio.
- `CH_BLANK`→`CH_ON` when the mask ends with the flag low.
- `CH_BLANK`→`CH_TRIP` when the mask ends with the flag high.
- `CH_ON`→`CH_TRIP` on the flag.
- `CH_ON`/`CH_TRIP`/`CH_BLANK`→`CH_BLANK` at a boundary.
- Any state→`CH_IDLE` at a boundary with a zero ratio, or at any time on low enable.

The interlock has two states. `IL_DRIVE` passes the gate to the active side. `IL_DEAD` blocks both sides. It moves `IL_DRIVE`→`IL_DEAD` when the polarity differs from the active side. It moves `IL_DEAD`→`IL_DRIVE` after `DEAD_TICKS` ticks, and on that move it adopts the new polarity.

Top module: `chop_phase_ctrl`

## Requirements
- R1: After reset both gates and the period strobe stay low until the first period boundary.
- R2: `period_start` is high for one cycle every TICK_DIV×PERIOD_TICKS clock cycles; the clock edge that ends that cycle is the period boundary.
- R3: With enable high, a nonzero ratio and the flag low, the active gate is high in every cycle of the period, starting with the cycle after the boundary.
- R4: The over-current flag has no effect for BLANK_TICKS ticks (TICK_DIV×BLANK_TICKS cycles) after a boundary; the gate is high throughout that window.
- R5: A flag seen at a clock edge after the mask ends drops the gate from that edge until the next boundary.
- R6: A flag already high when the mask ends drops the gate at the edge that ends the mask.
- R7: A low enable drops both gates in the same cycle. A gate that is enabled again mid-period stays low until the next boundary.
- R8: A ratio code of 0 at a boundary keeps both gates low for that whole period.
- R9: On a polarity change, both gates stay low for DEAD_TICKS ticks before the new side is driven. This is exactly TICK_DIV×DEAD_TICKS cycles when the change is seen at a boundary edge.
- R10: `gate_p` and `gate_n` are never high together.
- R11: `gate_p` is the side driven when polarity is 1, and `gate_n` when polarity is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; low forces both gates off |
| polarity | input | 1 | Winding polarity from the sequencer (1 = positive side) |
| ratio_code | input | RATIO_W | Current-ratio code; 0 suppresses the pulse |
| ocp | input | 1 | Over-current flag from the sense comparator |
| gate_p | output | 1 | Gate drive, positive side |
| gate_n | output | 1 | Gate drive, negative side |
| period_start | output | 1 | One-cycle strobe before each period boundary |

## Verification
The bench builds the block with TICK_DIV=4, PERIOD_TICKS=6, BLANK_TICKS=2 and DEAD_TICKS=3. This gives a 24-cycle period, an 8-cycle mask and a 12-cycle dead interval. With these values every position of the comparator flag inside a period can be reached, including the last masked cycle and the first watched one. The same holds for an enable drop in mid-period and a polarity flip aligned to a boundary. The short period also lets the stimulus table cover each trip position in a few hundred cycles, while keeping the tick-based blanking and dead-time counters distinct from the raw clock.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_BLANK,
        CH_ON,
        CH_TRIP
    } chop_state_e;

    typedef enum logic {
        IL_DRIVE,
        IL_DEAD
    } ilk_state_e;

endpackage

// File: rtl/chop_period_gen.sv
module chop_period_gen #(
    parameter int TICK_DIV     = 63,
    parameter int PERIOD_TICKS = 18
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic pstart
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;

    logic [TW-1:0] tcnt;
    logic [PW-1:0] pcnt;

    assign tick   = (tcnt == TW'(TICK_DIV - 1));
    assign pstart = tick && (pcnt == PW'(PERIOD_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            pcnt <= '0;
        end else begin
            tcnt <= tick ? '0 : tcnt + TW'(1);
            if (pstart)
                pcnt <= '0;
            else if (tick)
                pcnt <= pcnt + PW'(1);
        end
    end

    // R2
    period_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt < PW'(PERIOD_TICKS) || PERIOD_TICKS == (1 << PW));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstart && TICK_DIV * PERIOD_TICKS > 1) |=> !pstart);

endmodule

// File: rtl/chop_gate_fsm.sv
module chop_gate_fsm
    import chop_pkg::*;
#(
    parameter int BLANK_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pstart,
    input  logic en,
    input  logic ratio_zero,
    input  logic ocp,
    output logic drive
);
    localparam int BW = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;

    chop_state_e   state, nxt;
    logic [BW-1:0] bcnt;
    logic          go;
    logic          blank_done;

    assign go         = en && !ratio_zero;
    assign blank_done = tick && (bcnt == BW'(BLANK_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            bcnt  <= '0;
        end else begin
            state <= nxt;
            if (pstart || state != CH_BLANK)
                bcnt <= '0;
            else if (tick)
                bcnt <= bcnt + BW'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE:  if (pstart && go) nxt = CH_BLANK;
            CH_BLANK: begin
                if (pstart)          nxt = go ? CH_BLANK : CH_IDLE;
                else if (blank_done) nxt = ocp ? CH_TRIP : CH_ON;
            end
            CH_ON: begin
                if (pstart)   nxt = go ? CH_BLANK : CH_IDLE;
                else if (ocp) nxt = CH_TRIP;
            end
            CH_TRIP:  if (pstart) nxt = go ? CH_BLANK : CH_IDLE;
            default:  nxt = CH_IDLE;
        endcase
        if (!en) nxt = CH_IDLE;
        drive = (state == CH_BLANK) || (state == CH_ON);
    end

    // R3
    start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(pstart));

    // R5
    trip_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_TRIP && !pstart && en) |=> state == CH_TRIP);

    // R7
    disable_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == CH_IDLE);

    // R4
    blank_ignores_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_BLANK && !blank_done && !pstart && en) |=> state == CH_BLANK);

endmodule

// File: rtl/chop_interlock.sv
module chop_interlock
    import chop_pkg::*;
#(
    parameter int DEAD_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pol,
    output logic side,
    output logic pass
);
    localparam int DW = (DEAD_TICKS > 1) ? $clog2(DEAD_TICKS) : 1;

    ilk_state_e    state, nxt;
    logic [DW-1:0] dcnt;
    logic          dead_done;

    assign dead_done = tick && (dcnt == DW'(DEAD_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IL_DRIVE;
            side  <= 1'b1;
            dcnt  <= '0;
        end else begin
            state <= nxt;
            if (state == IL_DEAD && nxt == IL_DRIVE)
                side <= pol;
            if (state != IL_DEAD)
                dcnt <= '0;
            else if (tick)
                dcnt <= dcnt + DW'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            IL_DRIVE: if (pol != side) nxt = IL_DEAD;
            IL_DEAD:  if (dead_done)   nxt = IL_DRIVE;
            default:  nxt = IL_DRIVE;
        endcase
        pass = (state == IL_DRIVE);
    end

    // R9
    flip_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IL_DRIVE && pol != side) |=> !pass);

    // R9
    side_moves_after_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(side) |-> $past(state == IL_DEAD));

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl #(
    parameter int TICK_DIV     = 63,
    parameter int PERIOD_TICKS = 18,
    parameter int BLANK_TICKS  = 2,
    parameter int DEAD_TICKS   = 3,
    parameter int RATIO_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               polarity,
    input  logic [RATIO_W-1:0] ratio_code,
    input  logic               ocp,
    output logic               gate_p,
    output logic               gate_n,
    output logic               period_start
);
    logic tick;
    logic pstart;
    logic drive;
    logic side;
    logic pass;
    logic live;

    chop_period_gen #(
        .TICK_DIV    (TICK_DIV),
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pstart(pstart)
    );

    chop_gate_fsm #(
        .BLANK_TICKS(BLANK_TICKS)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pstart    (pstart),
        .en        (en),
        .ratio_zero(ratio_code == '0),
        .ocp       (ocp),
        .drive     (drive)
    );

    chop_interlock #(
        .DEAD_TICKS(DEAD_TICKS)
    ) u_ilk (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .pol  (polarity),
        .side (side),
        .pass (pass)
    );

    assign live         = en && drive && pass;
    assign gate_p       = live && side;
    assign gate_n       = live && !side;
    assign period_start = pstart;

    // R10
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_p && gate_n));

endmodule

// File: tb/chop_phase_ctrl_test.sv
module chop_phase_ctrl_test;

    localparam int TD = 4, PT = 6, BT = 2, DT = 3;
    localparam int PER   = TD * PT;
    localparam int BLANK = TD * BT;
    localparam int DEAD  = TD * DT;
    localparam int NV    = 8;

    // fields: [12] en, [11:8] ratio, [7:0] flag offset (255 = never)
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'd5,  8'd255},
        {1'b1, 4'd5,  8'd3},
        {1'b1, 4'd5,  8'd12},
        {1'b1, 4'd0,  8'd255},
        {1'b0, 4'd5,  8'd255},
        {1'b1, 4'd15, 8'd7},
        {1'b1, 4'd1,  8'd8},
        {1'b1, 4'd5,  8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       polarity = 1'b1;
    logic [3:0] ratio_code = 4'd5;
    logic       ocp = 1'b0;
    logic       gate_p, gate_n, period_start;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    chop_phase_ctrl #(
        .TICK_DIV(TD), .PERIOD_TICKS(PT), .BLANK_TICKS(BT),
        .DEAD_TICKS(DT), .RATIO_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .polarity(polarity),
        .ratio_code(ratio_code), .ocp(ocp),
        .gate_p(gate_p), .gate_n(gate_n), .period_start(period_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sync_boundary();
        do @(negedge clk); while (!period_start);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        int on_p, on_n, gap, first_n;
        bit leak;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        leak = 1'b0;
        for (int j = 0; j < PER - 2; j++) begin
            @(negedge clk);
            if (gate_p || gate_n || period_start) leak = 1'b1;
        end
        check(!leak, "R1 quiet before first boundary", leak, 0);

        // R2: strobe spacing
        sync_boundary();
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!period_start);
        check(gap == PER, "R2 period length", gap, PER);

        // R3 R4 R5 R6 R7 R8: table of period patterns
        for (int v = 0; v < NV; v++) begin
            int exp_on;
            int at;
            sync_boundary();
            en = VEC[v][12];
            ratio_code = VEC[v][11:8];
            at = int'(VEC[v][7:0]);
            ocp = 1'b0;
            if (!VEC[v][12] || VEC[v][11:8] == 4'd0) exp_on = 0;
            else if (at == 255) exp_on = PER;
            else if (at < BLANK) exp_on = BLANK;
            else exp_on = at + 1;
            on_p = 0;
            on_n = 0;
            for (int j = 0; j < PER; j++) begin
                @(negedge clk);
                if (gate_p) on_p++;
                if (gate_n) on_n++;
                if (at == j) ocp = 1'b1;
            end
            check(on_p == exp_on, $sformatf("R3/R4/R5/R6/R7/R8 row %0d on-cycles", v), on_p, exp_on);
            check(on_n == 0, $sformatf("R11 row %0d opposite side", v), on_n, 0);
        end

        // R7: enable drop mid-period
        sync_boundary();
        en = 1'b1; ratio_code = 4'd5; ocp = 1'b0;
        repeat (10) @(negedge clk);
        check(gate_p == 1'b1, "R7 on before drop", gate_p, 1);
        en = 1'b0;
        #1;
        check(gate_p == 1'b0, "R7 off same cycle", gate_p, 0);
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(gate_p == 1'b0, "R7 stays off after re-enable", gate_p, 0);
        sync_boundary();
        @(negedge clk);
        check(gate_p == 1'b1, "R7 back on at boundary", gate_p, 1);

        // R9 R10 R11: polarity flip at a boundary
        sync_boundary();
        polarity = 1'b0;
        first_n = -1;
        on_p = 0;
        leak = 1'b0;
        for (int j = 0; j < PER; j++) begin
            @(negedge clk);
            if (gate_p) on_p++;
            if (gate_p && gate_n) leak = 1'b1;
            if (gate_n && first_n < 0) first_n = j;
        end
        check(first_n == DEAD, "R9 dead interval length", first_n, DEAD);
        check(on_p == 0, "R9 old side blocked", on_p, 0);
        check(!leak, "R10 never both high", leak, 0);
        check(gate_n == 1'b1, "R11 negative side driven", gate_n, 1);

        // R4: negative side still respects blanking
        sync_boundary();
        ocp = 1'b1;
        repeat (BLANK) @(negedge clk);
        check(gate_n == 1'b1, "R4 flag masked on negative side", gate_n, 1);
        @(negedge clk);
        check(gate_n == 1'b0, "R6 flag high at mask end", gate_n, 0);
        ocp = 1'b0;

        report();
    end

endmodule